// File: doc/BRIEF.md
# Subroutine Frame Sequencer

This block performs the memory side of a subroutine call or return. A processor core starts it with a one-cycle strobe and supplies the current PC, stack pointer, frame pointer and call target. The block then makes the frame's memory accesses one word at a time through a single 32-bit memory port. When the last access completes, it presents the new stack pointer, frame pointer and PC and raises a one-cycle completion strobe.

A frame is three words long. A call leaves the highest word of the new frame as a reserved slot and never writes it. The call then writes the return address into the middle word and the caller's frame pointer into the lowest word. After a call, the stack pointer and frame pointer both point at the lowest word. A return works from the frame pointer. It reads the saved frame pointer and then the return address, and places the stack pointer just above the three-word frame.

There are two kinds of call. An absolute call follows a 6-byte instruction. A register call follows a 2-byte instruction. The two differ only in the offset added to the PC to form the return address. Instruction decoding is done elsewhere.

Top module: `frame_sequencer`

## Requirements
- R1: After reset, `mem_req_o` and `done_o` are 0, and `sp_o`, `fp_o` and `pc_o` are all 0.
- R2: The first access of a call is a write (`mem_we_o`=1) at SP-8 that stores the return address. No access of any kind is made to the reserved word at SP-4.
- R3: The second access of a call is a write at SP-12 that stores the frame pointer captured at the start.
- R4: When a call completes, `sp_o` and `fp_o` both equal SP-12, and `pc_o` equals the captured target.
- R5: The return address is PC+6 for an absolute call and PC+2 for a register call.
- R6: A return makes exactly two reads (`mem_we_o`=0), first at FP and then at FP+4, and no writes. On completion, `fp_o` holds the word read from FP, `pc_o` holds the word read from FP+4, and `sp_o` equals FP+12.
- R7: An access keeps `mem_req_o`, `mem_addr_o`, `mem_we_o` and `mem_wdata_o` unchanged until `mem_ready_i` is seen high. Each access ends in the cycle where ready is high. `done_o` rises 1+2*(L+1) cycles after the start strobe is sampled, where each access waits L cycles for ready.
- R8: `done_o` is high for exactly one cycle per sequence, and only after a cycle in which an access completed. `sp_o`, `fp_o` and `pc_o` keep their values until the next completion.
- R9: Start strobes that arrive while a sequence is in progress are ignored. They make no further accesses and do not change the result.
- R10: When several strobes are high in the same idle cycle, the absolute call wins over the register call, and the register call wins over the return.
- R11: PC, SP, FP and the target are captured in the start cycle. Changes to them during a sequence have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_abs_i | input | 1 | Start strobe for an absolute-address call |
| call_reg_i | input | 1 | Start strobe for a register call |
| ret_i | input | 1 | Start strobe for a return |
| target_i | input | 32 | Call target address |
| pc_i | input | 32 | PC of the call instruction |
| sp_i | input | 32 | Current stack pointer |
| fp_i | input | 32 | Current frame pointer |
| mem_rdata_i | input | 32 | Memory read data, valid with ready |
| mem_ready_i | input | 1 | Memory completes the current access |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 32 | Byte address of the access |
| mem_wdata_o | output | 32 | Write data |
| sp_o | output | 32 | New stack pointer |
| fp_o | output | 32 | New frame pointer |
| pc_o | output | 32 | New PC |
| done_o | output | 1 | One-cycle completion strobe |

## Verification
A wrong state in this block appears at the memory port within one access. The symptoms are a wrong address, a write where a read belongs, an access to the reserved slot, or a third access. Because the bench logs every completed access, these show up before `done_o` rises. A wrong captured register or a missed transition changes `sp_o`, `fp_o` or `pc_o`, or the cycle on which `done_o` rises, at the completion of the same sequence. Memory latency is varied so that a sequencer that moves on without ready shows up as an early completion.

// File: rtl/frame_seq_pkg.sv
package frame_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_WR_LINK  = 3'd1,
        ST_WR_FRAME = 3'd2,
        ST_RD_FRAME = 3'd3,
        ST_RD_LINK  = 3'd4,
        ST_FINISH   = 3'd5
    } seq_state_e;

    typedef enum logic [1:0] {
        OP_NONE     = 2'd0,
        OP_CALL_ABS = 2'd1,
        OP_CALL_REG = 2'd2,
        OP_RETURN   = 2'd3
    } seq_op_e;

endpackage

// File: rtl/fseq_pick.sv
module fseq_pick
    import frame_seq_pkg::*;
(
    input  logic    idle_i,
    input  logic    call_abs_i,
    input  logic    call_reg_i,
    input  logic    ret_i,
    output seq_op_e op_o
);
    // Fixed priority: absolute call, register call, return (R10).
    // Strobes outside idle are dropped (R9).
    always_comb begin
        op_o = OP_NONE;
        if (idle_i) begin
            if (call_abs_i)      op_o = OP_CALL_ABS;
            else if (call_reg_i) op_o = OP_CALL_REG;
            else if (ret_i)      op_o = OP_RETURN;
        end
    end
endmodule

// File: rtl/fseq_addr.sv
module fseq_addr
    import frame_seq_pkg::*;
#(
    parameter int W        = 32,
    parameter int WB       = 4,
    parameter int ABS_STEP = 6,
    parameter int REG_STEP = 2
) (
    input  seq_op_e        op_i,
    input  logic [W-1:0]   base_i,
    input  logic [W-1:0]   pc_i,
    output logic [W-1:0]   link_addr_o,
    output logic [W-1:0]   frame_addr_o,
    output logic [W-1:0]   pop_link_addr_o,
    output logic [W-1:0]   ret_sp_o,
    output logic [W-1:0]   ret_addr_o
);
    localparam int LINK_OFS  = 2 * WB;   // past the reserved slot
    localparam int FRAME_OFS = 3 * WB;   // full frame size

    assign link_addr_o     = base_i - W'(LINK_OFS);
    assign frame_addr_o    = base_i - W'(FRAME_OFS);
    assign pop_link_addr_o = base_i + W'(WB);
    assign ret_sp_o        = base_i + W'(FRAME_OFS);
    assign ret_addr_o      = pc_i + ((op_i == OP_CALL_ABS) ? W'(ABS_STEP) : W'(REG_STEP));
endmodule

// File: rtl/fseq_ctrl.sv
module fseq_ctrl
    import frame_seq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  seq_op_e       op_start_i,
    input  logic [W-1:0]  pc_i,
    input  logic [W-1:0]  sp_i,
    input  logic [W-1:0]  fp_i,
    input  logic [W-1:0]  target_i,
    input  logic [W-1:0]  mem_rdata_i,
    input  logic          mem_ready_i,
    input  logic [W-1:0]  link_addr_i,
    input  logic [W-1:0]  frame_addr_i,
    input  logic [W-1:0]  pop_link_addr_i,
    input  logic [W-1:0]  ret_sp_i,
    input  logic [W-1:0]  ret_addr_i,
    output seq_op_e       op_o,
    output logic [W-1:0]  base_o,
    output logic [W-1:0]  pc_cap_o,
    output logic          idle_o,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [W-1:0]  mem_addr_o,
    output logic [W-1:0]  mem_wdata_o,
    output logic [W-1:0]  sp_o,
    output logic [W-1:0]  fp_o,
    output logic [W-1:0]  pc_o,
    output logic          done_o
);
    typedef struct packed {
        seq_state_e   st;
        seq_op_e      op;
        logic [W-1:0] base;
        logic [W-1:0] pc_cap;
        logic [W-1:0] fp_cap;
        logic [W-1:0] tgt;
        logic [W-1:0] fp_rd;
        logic [W-1:0] sp_res;
        logic [W-1:0] fp_res;
        logic [W-1:0] pc_res;
    } ctrl_t;

    ctrl_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            ST_IDLE: begin
                if (op_start_i != OP_NONE) begin
                    r_d.op     = op_start_i;
                    r_d.pc_cap = pc_i;
                    r_d.fp_cap = fp_i;
                    r_d.tgt    = target_i;
                    if (op_start_i == OP_RETURN) begin
                        r_d.base = fp_i;
                        r_d.st   = ST_RD_FRAME;
                    end else begin
                        r_d.base = sp_i;
                        r_d.st   = ST_WR_LINK;
                    end
                end
            end
            ST_WR_LINK: begin
                if (mem_ready_i) r_d.st = ST_WR_FRAME;
            end
            ST_WR_FRAME: begin
                if (mem_ready_i) begin
                    r_d.st     = ST_FINISH;
                    r_d.sp_res = frame_addr_i;
                    r_d.fp_res = frame_addr_i;
                    r_d.pc_res = r_q.tgt;
                end
            end
            ST_RD_FRAME: begin
                if (mem_ready_i) begin
                    r_d.fp_rd = mem_rdata_i;
                    r_d.st    = ST_RD_LINK;
                end
            end
            ST_RD_LINK: begin
                if (mem_ready_i) begin
                    r_d.st     = ST_FINISH;
                    r_d.fp_res = r_q.fp_rd;
                    r_d.pc_res = mem_rdata_i;
                    r_d.sp_res = ret_sp_i;
                end
            end
            ST_FINISH: r_d.st = ST_IDLE;
            default:   r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, op: OP_NONE, default: '0};
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        mem_req_o   = 1'b0;
        mem_we_o    = 1'b0;
        mem_addr_o  = '0;
        mem_wdata_o = '0;
        unique case (r_q.st)
            ST_WR_LINK: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = link_addr_i;
                mem_wdata_o = ret_addr_i;
            end
            ST_WR_FRAME: begin
                mem_req_o   = 1'b1;
                mem_we_o    = 1'b1;
                mem_addr_o  = frame_addr_i;
                mem_wdata_o = r_q.fp_cap;
            end
            ST_RD_FRAME: begin
                mem_req_o  = 1'b1;
                mem_addr_o = r_q.base;
            end
            ST_RD_LINK: begin
                mem_req_o  = 1'b1;
                mem_addr_o = pop_link_addr_i;
            end
            default: ;
        endcase
    end

    assign op_o     = r_q.op;
    assign base_o   = r_q.base;
    assign pc_cap_o = r_q.pc_cap;
    assign idle_o   = (r_q.st == ST_IDLE);
    assign done_o   = (r_q.st == ST_FINISH);
    assign sp_o     = r_q.sp_res;
    assign fp_o     = r_q.fp_res;
    assign pc_o     = r_q.pc_res;

    // R7: a pending access holds its request until ready
    p_hold_access_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && !mem_ready_i) |=>
            (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o) && $stable(mem_wdata_o)));

    // R8: completion lasts one cycle
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8: completion only follows a finished access
    p_done_after_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(mem_req_o && mem_ready_i));

    // R6: a return never writes
    p_return_reads_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_o && r_q.op == OP_RETURN) |-> !mem_we_o);

    // R4: after a call the stack and frame pointers agree
    p_call_frame_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && r_q.op != OP_RETURN) |-> (sp_o == fp_o));

    // R8: results hold between completions
    p_result_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!done_o && !$rose(done_o)) |=> (done_o || ($stable(sp_o) && $stable(fp_o) && $stable(pc_o))));
endmodule

// File: rtl/frame_sequencer.sv
module frame_sequencer
    import frame_seq_pkg::*;
#(
    parameter int W        = 32,
    parameter int WB       = W / 8,
    parameter int ABS_STEP = 6,
    parameter int REG_STEP = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          call_abs_i,
    input  logic          call_reg_i,
    input  logic          ret_i,
    input  logic [W-1:0]  target_i,
    input  logic [W-1:0]  pc_i,
    input  logic [W-1:0]  sp_i,
    input  logic [W-1:0]  fp_i,
    input  logic [W-1:0]  mem_rdata_i,
    input  logic          mem_ready_i,
    output logic          mem_req_o,
    output logic          mem_we_o,
    output logic [W-1:0]  mem_addr_o,
    output logic [W-1:0]  mem_wdata_o,
    output logic [W-1:0]  sp_o,
    output logic [W-1:0]  fp_o,
    output logic [W-1:0]  pc_o,
    output logic          done_o
);
    seq_op_e      op_start, op_cur;
    logic         idle;
    logic [W-1:0] base_cur, pc_cur;
    logic [W-1:0] link_addr, frame_addr, pop_link_addr, ret_sp, ret_addr;

    fseq_pick u_pick (
        .idle_i     (idle),
        .call_abs_i (call_abs_i),
        .call_reg_i (call_reg_i),
        .ret_i      (ret_i),
        .op_o       (op_start)
    );

    fseq_addr #(.W(W), .WB(WB), .ABS_STEP(ABS_STEP), .REG_STEP(REG_STEP)) u_addr (
        .op_i            (op_cur),
        .base_i          (base_cur),
        .pc_i            (pc_cur),
        .link_addr_o     (link_addr),
        .frame_addr_o    (frame_addr),
        .pop_link_addr_o (pop_link_addr),
        .ret_sp_o        (ret_sp),
        .ret_addr_o      (ret_addr)
    );

    fseq_ctrl #(.W(W)) u_ctrl (
        .clk             (clk),
        .rst_n           (rst_n),
        .op_start_i      (op_start),
        .pc_i            (pc_i),
        .sp_i            (sp_i),
        .fp_i            (fp_i),
        .target_i        (target_i),
        .mem_rdata_i     (mem_rdata_i),
        .mem_ready_i     (mem_ready_i),
        .link_addr_i     (link_addr),
        .frame_addr_i    (frame_addr),
        .pop_link_addr_i (pop_link_addr),
        .ret_sp_i        (ret_sp),
        .ret_addr_i      (ret_addr),
        .op_o            (op_cur),
        .base_o          (base_cur),
        .pc_cap_o        (pc_cur),
        .idle_o          (idle),
        .mem_req_o       (mem_req_o),
        .mem_we_o        (mem_we_o),
        .mem_addr_o      (mem_addr_o),
        .mem_wdata_o     (mem_wdata_o),
        .sp_o            (sp_o),
        .fp_o            (fp_o),
        .pc_o            (pc_o),
        .done_o          (done_o)
    );
endmodule

// File: tb/tb_frame_sequencer.sv
module tb_frame_sequencer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        call_abs = 1'b0, call_reg = 1'b0, ret = 1'b0;
    logic [31:0] target = '0, pc = '0, sp = '0, fp = '0;
    logic [31:0] mem_rdata;
    logic        mem_ready;
    logic        mem_req, mem_we, done;
    logic [31:0] mem_addr, mem_wdata, sp_o, fp_o, pc_o;

    always #5 clk = ~clk;

    frame_sequencer dut (
        .clk(clk), .rst_n(rst_n),
        .call_abs_i(call_abs), .call_reg_i(call_reg), .ret_i(ret),
        .target_i(target), .pc_i(pc), .sp_i(sp), .fp_i(fp),
        .mem_rdata_i(mem_rdata), .mem_ready_i(mem_ready),
        .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
        .mem_wdata_o(mem_wdata), .sp_o(sp_o), .fp_o(fp_o), .pc_o(pc_o),
        .done_o(done)
    );

    // memory model with programmable wait
    logic [31:0] mem [256];
    int          lat = 0;
    int          wait_q = 0;
    logic        log_clr = 1'b0;
    logic        pre_en = 1'b0;
    logic [31:0] pre_addr = '0, pre_data = '0;
    int          acc_n = 0;
    logic [31:0] acc_addr [8];
    logic [31:0] acc_data [8];
    logic        acc_we   [8];

    assign mem_ready = mem_req && (wait_q >= lat);
    assign mem_rdata = mem[mem_addr[9:2]];

    always @(posedge clk) begin
        if (!mem_req || mem_ready) wait_q <= 0;
        else                       wait_q <= wait_q + 1;
        if (pre_en) mem[pre_addr[9:2]] <= pre_data;
        else if (mem_req && mem_ready && mem_we) mem[mem_addr[9:2]] <= mem_wdata;
        if (log_clr) acc_n <= 0;
        else if (mem_req && mem_ready) begin
            if (acc_n < 8) begin
                acc_addr[acc_n] <= mem_addr;
                acc_data[acc_n] <= mem_we ? mem_wdata : mem_rdata;
                acc_we[acc_n]   <= mem_we;
            end
            acc_n <= acc_n + 1;
        end
    end

    int checks = 0, errors = 0;
    logic finished = 1'b0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic preload(input logic [31:0] a, input logic [31:0] d);
        pre_addr = a; pre_data = d; pre_en = 1'b1;
        @(negedge clk);
        pre_en = 1'b0;
    endtask

    // start a sequence; inj>0 pulses every strobe and scrambles inputs at that cycle
    task automatic launch(input logic a, input logic r, input logic t, input int inj, output int cyc);
        log_clr = 1'b1;
        @(negedge clk);
        log_clr = 1'b0;
        call_abs = a; call_reg = r; ret = t;
        @(negedge clk);
        call_abs = 1'b0; call_reg = 1'b0; ret = 1'b0;
        cyc = 1;
        while (!done && cyc < 64) begin
            if (cyc == inj) begin
                call_abs = 1'b1; call_reg = 1'b1; ret = 1'b1;
                pc = 32'hDEAD0000; sp = 32'h0000_0200; fp = 32'h0000_0240; target = 32'h0BAD0BAD;
            end else begin
                call_abs = 1'b0; call_reg = 1'b0; ret = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        call_abs = 1'b0; call_reg = 1'b0; ret = 1'b0;
    endtask

    task automatic check_call(input string tag, input logic [31:0] sp0, input logic [31:0] fp0,
                              input logic [31:0] pc0, input logic [31:0] tg0, input int step);
        chk({tag, " R2 link write addr"}, acc_addr[0], sp0 - 8);
        chk({tag, " R2 link write is write"}, 32'(acc_we[0]), 1);
        chk({tag, " R5 return address"}, acc_data[0], pc0 + 32'(step));
        chk({tag, " R3 frame write addr"}, acc_addr[1], sp0 - 12);
        chk({tag, " R3 saved fp"}, acc_data[1], fp0);
        chk({tag, " R4 sp"}, sp_o, sp0 - 12);
        chk({tag, " R4 fp"}, fp_o, sp0 - 12);
        chk({tag, " R4 pc"}, pc_o, tg0);
        chk({tag, " R2 slot word untouched"}, mem[(sp0 - 4) >> 2], 32'h5A5A5A5A);
    endtask

    task automatic t_reset();
        chk("R1 req", 32'(mem_req), 0);
        chk("R1 done", 32'(done), 0);
        chk("R1 sp", sp_o, 0);
        chk("R1 fp", fp_o, 0);
        chk("R1 pc", pc_o, 0);
    endtask

    task automatic t_call_abs();
        int cyc;
        lat = 0;
        sp = 32'h0000_0300; fp = 32'h0000_0380; pc = 32'h0000_1000; target = 32'h0000_4000;
        preload(32'h0000_02FC, 32'h5A5A5A5A);
        launch(1, 0, 0, 0, cyc);
        chk("R7 latency0 done cycle", 32'(cyc), 3);
        chk("R2 access count", 32'(acc_n), 2);
        check_call("abs", 32'h300, 32'h380, 32'h1000, 32'h4000, 6);
        @(negedge clk);
        chk("R8 done one cycle", 32'(done), 0);
        repeat (3) @(negedge clk);
        chk("R8 sp held", sp_o, 32'h2F4);
        chk("R8 pc held", pc_o, 32'h4000);
    endtask

    task automatic t_call_reg();
        int cyc;
        lat = 2;
        sp = 32'h0000_0200; fp = 32'h0000_0280; pc = 32'h0000_2222; target = 32'h0000_8888;
        preload(32'h0000_01FC, 32'h5A5A5A5A);
        launch(0, 1, 0, 0, cyc);
        chk("R7 latency2 done cycle", 32'(cyc), 7);
        check_call("reg", 32'h200, 32'h280, 32'h2222, 32'h8888, 2);
    endtask

    task automatic t_return();
        int cyc;
        lat = 1;
        preload(32'h0000_0100, 32'h0000_0390);
        preload(32'h0000_0104, 32'h0000_7006);
        fp = 32'h0000_0100; sp = 32'h0000_0050; pc = 32'h0000_1234;
        launch(0, 0, 1, 0, cyc);
        chk("R7 latency1 done cycle", 32'(cyc), 5);
        chk("R6 access count", 32'(acc_n), 2);
        chk("R6 first read addr", acc_addr[0], 32'h100);
        chk("R6 second read addr", acc_addr[1], 32'h104);
        chk("R6 no writes", 32'(acc_we[0] | acc_we[1]), 0);
        chk("R6 fp", fp_o, 32'h390);
        chk("R6 pc", pc_o, 32'h7006);
        chk("R6 sp", sp_o, 32'h10C);
    endtask

    task automatic t_busy_ignore();
        int cyc;
        lat = 1;
        sp = 32'h0000_0340; fp = 32'h0000_03A0; pc = 32'h0000_0500; target = 32'h0000_0600;
        preload(32'h0000_033C, 32'h5A5A5A5A);
        launch(1, 0, 0, 2, cyc);
        chk("R9 access count", 32'(acc_n), 2);
        check_call("R9 busy", 32'h340, 32'h3A0, 32'h500, 32'h600, 6);
        repeat (4) begin
            @(negedge clk);
            chk("R9 no access after done", 32'(mem_req), 0);
        end
    endtask

    task automatic t_capture();
        int cyc;
        lat = 3;
        sp = 32'h0000_0180; fp = 32'h0000_01C0; pc = 32'h0000_0A00; target = 32'h0000_0B00;
        preload(32'h0000_017C, 32'h5A5A5A5A);
        launch(0, 1, 0, 4, cyc);
        chk("R11 done cycle", 32'(cyc), 9);
        check_call("R11 capture", 32'h180, 32'h1C0, 32'h0A00, 32'h0B00, 2);
    endtask

    task automatic t_priority();
        int cyc;
        lat = 0;
        sp = 32'h0000_0260; fp = 32'h0000_0100; pc = 32'h0000_0C00; target = 32'h0000_0D00;
        preload(32'h0000_025C, 32'h5A5A5A5A);
        launch(1, 1, 1, 0, cyc);
        chk("R10 abs wins: first is write", 32'(acc_we[0]), 1);
        chk("R10 abs wins: step 6", acc_data[0], 32'h0C06);
        sp = 32'h0000_02A0;
        preload(32'h0000_029C, 32'h5A5A5A5A);
        launch(0, 1, 1, 0, cyc);
        chk("R10 reg over return: addr", acc_addr[0], 32'h298);
        chk("R10 reg over return: step 2", acc_data[0], 32'h0C02);
    endtask

    task automatic t_roundtrip();
        int cyc;
        lat = 1;
        sp = 32'h0000_03E0; fp = 32'h0000_03F0; pc = 32'h0000_0E00; target = 32'h0000_0F00;
        preload(32'h0000_03DC, 32'h5A5A5A5A);
        launch(1, 0, 0, 0, cyc);
        fp = fp_o; sp = sp_o;
        launch(0, 0, 1, 0, cyc);
        chk("R6 roundtrip sp", sp_o, 32'h3E0);
        chk("R6 roundtrip fp", fp_o, 32'h3F0);
        chk("R5 roundtrip pc", pc_o, 32'h0E06);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_call_abs();
        t_call_reg();
        t_return();
        t_busy_ignore();
        t_capture();
        t_priority();
        t_roundtrip();
        if (!finished) begin
            finished = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #2000000;
        if (!finished) begin
            finished = 1'b1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule